// File: doc/BRIEF.md
# Reconfigurable Pin Function Crossbar

This block sits between a bank of eight general-purpose port pins and the on-chip digital peripherals. Each pin has a 5-bit selector register. The selector decides three things for that pin: which peripheral function drives it, which peripheral input hears it, and who controls its direction. The direction comes either from the port's own direction bit or from the selected peripheral. The pad logic receives, for each pin, an output value, an output enable, an open-drain flag and an input-buffer enable.

Peripheral functions are arranged in slots, one per selector code. Slot `c` offers `fnOut[c]` and `fnOe[c]` and receives `fnIn[c]`. Software programs the selectors over a small synchronous write bus. It reads them back on a combinational read path that shares the write address.

Selector code map (5-bit code):

| Code | Behaviour |
|------|-----------|
| 0, 18–30 | No function; drives low when enabled |
| 1–10 | Paired input/output functions; the port direction bit is the enable |
| 11–13, 16 | Serial functions; the peripheral supplies the enable |
| 14, 15 | Two-wire serial functions; open-drain, peripheral direction |
| 17 | Output-only function; the port direction bit is the enable |
| 31 | Analog: driver and input buffer both off |

Top module: `pin_func_xbar`

## Requirements
- R1: Each selector register is 5 bits wide. A write stores `wrData[4:0]` and drops the upper bits. `rdData` returns `{3'b000, selector}` for the pin at `addr`, so writing 0xFF reads back as 31.
- R2: After reset, pins 0 to 5 hold codes 13, 15, 14, 16, 12 and 11 in that order, and pins 6 and 7 hold code 0.
- R3: For code 0 and the reserved codes 18 to 30, the pin behaves as follows:
  - `pinOut` is 0.
  - `pinOe` equals the pin's `portDir` bit.
  - The pin feeds no `fnIn` bit.
- R4: For code 31, the pin behaves as follows:
  - `pinOe`, `pinOut`, `pinOd` and `pinInEn` are all 0.
  - The pin feeds no `fnIn` bit.
  - For every other code, `pinInEn` is 1.
- R5: For codes 1 to 10, the pin behaves as follows:
  - `pinOut` equals `fnOut[code]`.
  - `pinOe` equals the pin's `portDir` bit.
  - The pin's input is delivered to `fnIn[code]`.
- R6: For code 17, `pinOut` equals `fnOut[17]` and `pinOe` equals the `portDir` bit. `fnIn[17]` is always 0.
- R7: For codes 11, 12, 13 and 16, the pin behaves as follows:
  - `pinOut` equals `fnOut[code]`.
  - `pinOe` equals `fnOe[code]`, regardless of `portDir`.
  - The pin's input is delivered to `fnIn[code]`.
- R8: For codes 14 and 15, the pin behaves as follows:
  - `pinOd` is 1 and `pinOut` is 0.
  - `pinOe` equals `fnOe[code] & ~fnOut[code]`, so the pin only pulls low or releases.
  - The pin's input is delivered to `fnIn[code]`.
- R9: Each `fnIn[c]` is the OR of `pinIn` over all pins whose selector routes code `c`. It is 0 when no pin selects `c`. `fnIn[0]` and `fnIn[31]` are always 0.
- R10: A write is taken at the rising clock edge and changes only the addressed register. The pin outputs follow the new code from that edge onward. Without `wrEn`, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Selector write strobe |
| addr | input | 3 | Pin index for write and read |
| wrData | input | 8 | Write data; only bits 4:0 are kept |
| rdData | output | 8 | Selector of the addressed pin, zero-extended |
| portDir | input | 8 | Port direction bits (1 = drive) |
| fnOut | input | 32 | Peripheral output value per code slot |
| fnOe | input | 32 | Peripheral direction per code slot |
| pinIn | input | 8 | Pad input values |
| fnIn | output | 32 | Routed pin inputs per code slot |
| pinOut | output | 8 | Pad output value |
| pinOe | output | 8 | Pad output enable |
| pinOd | output | 8 | Pad open-drain mode |
| pinInEn | output | 8 | Pad input-buffer enable |

## Verification
A corrupted selector shows up on the read port at once, because the read path has no register. It also shows up on that pin's four pad controls and on the `fnIn` slot it feeds, in the same cycle as the bad value. A faulty decode, such as a reserved code that drives high or an open-drain line that drives high, is visible at the pad outputs as soon as the code is written: one clock edge after the write strobe. The tests therefore hold the peripheral slots, the port direction bits and the pad inputs at known patterns, then compare every affected output right after each write.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int CODE_W     = 5;
  localparam int NUM_CODES  = 1 << CODE_W;
  localparam int CODE_NONE  = 0;
  localparam int CODE_ANALOG = NUM_CODES - 1;
  localparam int PAIR_FIRST = 1;
  localparam int PAIR_LAST  = 10;
  localparam int SER_FIRST  = 11;
  localparam int SER_LAST   = 16;
  localparam int OD_A       = 14;
  localparam int OD_B       = 15;
  localparam int OUT_ONLY   = 17;

  // Strobes handed from the selector registers to the routing datapath.
  typedef struct packed {
    logic [CODE_W-1:0] sel;
    logic              drvFn;     // pad value comes from fnOut[sel]
    logic              periphDir; // direction from fnOe[sel]
    logic              openDrain;
    logic              analog;
    logic              routeIn;   // pad input feeds fnIn[sel]
  } pinCtl_t;

  function automatic logic [CODE_W-1:0] resetCode(input int pin);
    case (pin)
      0: resetCode = 5'd13;
      1: resetCode = 5'd15;
      2: resetCode = 5'd14;
      3: resetCode = 5'd16;
      4: resetCode = 5'd12;
      5: resetCode = 5'd11;
      default: resetCode = 5'd0;
    endcase
  endfunction

  function automatic pinCtl_t decodeCode(input logic [CODE_W-1:0] c);
    pinCtl_t d;
    int ci;
    ci = int'(c);
    d = '0;
    d.sel = c;
    if (ci == CODE_ANALOG) begin
      d.analog = 1'b1;
    end else if (ci >= PAIR_FIRST && ci <= PAIR_LAST) begin
      d.drvFn   = 1'b1;
      d.routeIn = 1'b1;
    end else if (ci >= SER_FIRST && ci <= SER_LAST) begin
      d.drvFn     = 1'b1;
      d.routeIn   = 1'b1;
      d.periphDir = 1'b1;
      d.openDrain = (ci == OD_A) || (ci == OD_B);
    end else if (ci == OUT_ONLY) begin
      d.drvFn = 1'b1;
    end
    return d;
  endfunction
endpackage

// File: rtl/xbar_map_ctrl.sv
module xbar_map_ctrl
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wrData,
  output logic [DATA_W-1:0]           rdData,
  output pinCtl_t [NUM_PINS-1:0]      pinCtl
);
  logic [NUM_PINS-1:0][CODE_W-1:0] mapReg;
  logic addrOk;

  assign addrOk = int'(addr) < NUM_PINS;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mapReg[p] <= resetCode(p);
      else if (wrEn && int'(addr) == p)
        mapReg[p] <= wrData[CODE_W-1:0];
    end
    assign pinCtl[p] = decodeCode(mapReg[p]);
  end

  always_comb begin
    rdData = '0;
    if (addrOk)
      rdData[CODE_W-1:0] = mapReg[addr];
  end

  // R1
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addrOk) |=> rdData[CODE_W-1:0] == $past(wrData[CODE_W-1:0]) || addr != $past(addr));

  // R10
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(mapReg));

  // R1
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:CODE_W] == '0);
endmodule

// File: rtl/xbar_route.sv
module xbar_route
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pinCtl_t [NUM_PINS-1:0] pinCtl,
  input  logic [NUM_PINS-1:0]    portDir,
  input  logic [NUM_CODES-1:0]   fnOut,
  input  logic [NUM_CODES-1:0]   fnOe,
  input  logic [NUM_PINS-1:0]    pinIn,
  output logic [NUM_CODES-1:0]   fnIn,
  output logic [NUM_PINS-1:0]    pinOut,
  output logic [NUM_PINS-1:0]    pinOe,
  output logic [NUM_PINS-1:0]    pinOd,
  output logic [NUM_PINS-1:0]    pinInEn
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pinCtl_t c;
    logic srcVal, srcOe;
    assign c      = pinCtl[p];
    assign srcVal = fnOut[c.sel];
    assign srcOe  = fnOe[c.sel];

    always_comb begin
      pinInEn[p] = !c.analog;
      pinOd[p]   = 1'b0;
      pinOut[p]  = 1'b0;
      pinOe[p]   = 1'b0;
      if (c.analog) begin
        pinOe[p] = 1'b0;
      end else if (c.openDrain) begin
        pinOd[p] = 1'b1;
        pinOe[p] = srcOe & ~srcVal;
      end else if (c.periphDir) begin
        pinOut[p] = srcVal;
        pinOe[p]  = srcOe;
      end else begin
        pinOut[p] = c.drvFn & srcVal;
        pinOe[p]  = portDir[p];
      end
    end

    // R4
    analog_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      (int'(c.sel) == CODE_ANALOG) |-> (!pinOe[p] && !pinInEn[p] && !pinOut[p]));

    // R8
    od_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      pinOd[p] |-> !pinOut[p]);

    // R3
    none_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (c.sel == '0) |-> (!pinOut[p] && pinOe[p] == portDir[p]));
  end

  always_comb begin
    fnIn = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (pinCtl[p].routeIn)
        fnIn[pinCtl[p].sel] = fnIn[pinCtl[p].sel] | pinIn[p];
    end
  end

  // R9
  unused_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fnIn[CODE_NONE] && !fnIn[CODE_ANALOG] && !fnIn[OUT_ONLY]);
endmodule

// File: rtl/pin_func_xbar.sv
module pin_func_xbar
  import pin_xbar_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic [7:0]  portDir,
  input  logic [31:0] fnOut,
  input  logic [31:0] fnOe,
  input  logic [7:0]  pinIn,
  output logic [31:0] fnIn,
  output logic [7:0]  pinOut,
  output logic [7:0]  pinOe,
  output logic [7:0]  pinOd,
  output logic [7:0]  pinInEn
);
  localparam int NUM_PINS = 8;
  pinCtl_t [NUM_PINS-1:0] pinCtl;

  xbar_map_ctrl #(.NUM_PINS(NUM_PINS), .DATA_W(8)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinCtl(pinCtl)
  );

  xbar_route #(.NUM_PINS(NUM_PINS)) route_i (
    .clk(clk), .rstN(rstN), .pinCtl(pinCtl), .portDir(portDir),
    .fnOut(fnOut), .fnOe(fnOe), .pinIn(pinIn), .fnIn(fnIn),
    .pinOut(pinOut), .pinOe(pinOe), .pinOd(pinOd), .pinInEn(pinInEn)
  );
endmodule

// File: tb/pin_func_xbar_tb.sv
module pin_func_xbar_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [7:0]  portDir = '0;
  logic [31:0] fnOut = '0;
  logic [31:0] fnOe = '0;
  logic [7:0]  pinIn = '0;
  logic [31:0] fnIn;
  logic [7:0]  pinOut, pinOe, pinOd, pinInEn;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_func_xbar dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .portDir(portDir), .fnOut(fnOut), .fnOe(fnOe),
    .pinIn(pinIn), .fnIn(fnIn), .pinOut(pinOut), .pinOe(pinOe),
    .pinOd(pinOd), .pinInEn(pinInEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a[2:0]; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    addr = a[2:0];
    #1;
    v = rdData;
  endtask

  task automatic clearStim();
    portDir = '0; fnOut = '0; fnOe = '0; pinIn = '0;
    #1;
  endtask

  task automatic testReset();
    logic [7:0] v;
    logic [7:0] exp [8] = '{8'd13, 8'd15, 8'd14, 8'd16, 8'd12, 8'd11, 8'd0, 8'd0};
    for (int p = 0; p < 8; p++) begin
      rd(p, v);
      chk("R2 reset code", v, exp[p]);
    end
    chk("R4 inEn all on after reset", pinInEn, 8'hFF);
  endtask

  task automatic testTruncAnalog();
    logic [7:0] v;
    wr(6, 8'hFF);
    rd(6, v);
    chk("R1 0xFF reads 31", v, 8'd31);
    portDir = 8'hFF; fnOut = '1; fnOe = '1; pinIn = 8'h40; #1;
    chk("R4 analog oe", pinOe[6], 1'b0);
    chk("R4 analog inEn", pinInEn[6], 1'b0);
    chk("R4 analog out", pinOut[6], 1'b0);
    chk("R4 analog no route", fnIn, 32'h0);
    clearStim();
  endtask

  task automatic testReserved();
    wr(7, 8'd20);
    portDir = 8'h80; fnOut = '1; pinIn = 8'h80; #1;
    chk("R3 code20 out low", pinOut[7], 1'b0);
    chk("R3 code20 oe=portDir", pinOe[7], 1'b1);
    chk("R3 code20 no route", fnIn, 32'h0);
    wr(7, 8'hE0 | 8'd18);
    portDir = 8'h00; #1;
    chk("R3 code18 oe=portDir", pinOe[7], 1'b0);
    chk("R3 code18 out low", pinOut[7], 1'b0);
    chk("R1 upper bits dropped", fnIn, 32'h0);
    clearStim();
  endtask

  task automatic testPaired();
    @(negedge clk);
    wrEn = 1'b1; addr = 3'd6; wrData = 8'd5;
    #1;
    chk("R10 old code before edge", pinInEn[6], 1'b0);
    @(negedge clk);
    wrEn = 1'b0;
    chk("R10 new code after edge", pinInEn[6], 1'b1);
    fnOut = 32'h1 << 5; portDir = 8'h40; #1;
    chk("R5 out follows fnOut", pinOut[6], 1'b1);
    chk("R5 oe follows portDir", pinOe[6], 1'b1);
    fnOut = '0; portDir = 8'h00; #1;
    chk("R5 out low", pinOut[6], 1'b0);
    chk("R5 oe off", pinOe[6], 1'b0);
    pinIn = 8'h40; #1;
    chk("R5 input routed", fnIn, 32'h1 << 5);
    clearStim();
  endtask

  task automatic testOutOnly();
    wr(7, 8'd17);
    fnOut = 32'h1 << 17; portDir = 8'h80; pinIn = 8'h80; #1;
    chk("R6 out", pinOut[7], 1'b1);
    chk("R6 oe", pinOe[7], 1'b1);
    chk("R6 no input", fnIn[17], 1'b0);
    clearStim();
  endtask

  task automatic testSerial();
    fnOut = 32'h1 << 12; fnOe = 32'h1 << 12; portDir = 8'h00; #1;
    chk("R7 oe from peripheral", pinOe[4], 1'b1);
    chk("R7 out", pinOut[4], 1'b1);
    fnOe = '0; portDir = 8'hFF; #1;
    chk("R7 portDir ignored", pinOe[4], 1'b0);
    chk("R7 not open drain", pinOd[4], 1'b0);
    portDir = '0; pinIn = 8'h10; #1;
    chk("R7 input routed", fnIn, 32'h1 << 12);
    clearStim();
  endtask

  task automatic testOpenDrain();
    fnOut = 32'h1 << 15; fnOe = 32'h1 << 15; portDir = 8'hFF; #1;
    chk("R8 od flag", pinOd[1], 1'b1);
    chk("R8 release on high", pinOe[1], 1'b0);
    chk("R8 out low", pinOut[1], 1'b0);
    fnOut = '0; #1;
    chk("R8 pull low", pinOe[1], 1'b1);
    chk("R8 out stays low", pinOut[1], 1'b0);
    fnOe = '0; #1;
    chk("R8 off when peripheral off", pinOe[1], 1'b0);
    pinIn = 8'h02; #1;
    chk("R8 input routed", fnIn, 32'h1 << 15);
    clearStim();
  endtask

  task automatic testOrMerge();
    wr(6, 8'd3);
    wr(7, 8'd3);
    pinIn = 8'h40; #1;
    chk("R9 one pin high", fnIn, 32'h1 << 3);
    pinIn = 8'h00; #1;
    chk("R9 both low", fnIn, 32'h0);
    pinIn = 8'h80; #1;
    chk("R9 other pin high", fnIn, 32'h1 << 3);
    pinIn = 8'hC0;
    wr(6, 8'd0);
    wr(7, 8'd0);
    chk("R9 unselected slot idle", fnIn, 32'h0);
    clearStim();
  endtask

  task automatic testAddressed();
    logic [7:0] v;
    wr(2, 8'd9);
    rd(2, v);
    chk("R10 addressed written", v, 8'd9);
    rd(1, v);
    chk("R10 neighbour kept", v, 8'd15);
    rd(3, v);
    chk("R10 neighbour kept", v, 8'd16);
    @(negedge clk); addr = 3'd2; wrData = 8'd1;
    @(negedge clk); @(negedge clk);
    rd(2, v);
    chk("R10 no strobe no change", v, 8'd9);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTruncAnalog();
    testReserved();
    testPaired();
    testOutOnly();
    testSerial();
    testOpenDrain();
    testOrMerge();
    testAddressed();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule